// File: doc/BRIEF.md
# Two-Stage Packed-Decimal Adder/Subtractor

This unit is the arithmetic slice of a small CPU datapath. It adds or subtracts two packed operands of two digits (eight bits by default), in plain binary or in packed decimal. Every 4-bit nibble has its own adder. Beside each adder a detector works out the decimal carry of that nibble. A multiplexer, controlled by the decimal-enable input, chooses which carry feeds the next nibble. The raw nibble sum, the chosen carries and the overflow bit are captured in a first register stage.

A second stage holds one small 4-bit correction adder per nibble. Each adder adds a constant to its nibble of the captured sum: 6 after a decimal add whose nibble carried, 10 (that is, minus 6 modulo 16) after a decimal subtract whose nibble did not carry, and 0 otherwise. The corrected value, the carry and the N, V and Z flags are registered as outputs. N, V and Z are taken from the uncorrected intermediate sum. A valid strobe travels with the data, so one operation can be accepted on every cycle and its result appears two clock edges later.

Top module: `bcdAluPipe`

## Requirements
- R1: With decimalEn low and subtract low, result equals (opA + opB + carryIn) mod 256, and carryOut is the carry out of bit 7.
- R2: With decimalEn low and subtract high, result equals (opA + ~opB + carryIn) mod 256, and carryOut is the carry out of bit 7 (1 means no borrow).
- R3: With decimalEn high, subtract low and valid packed-decimal operands (each nibble 0..9, high nibble = tens), result is the packed-decimal form of (A + B + carryIn) mod 100, and carryOut is 1 exactly when that sum is 100 or more.
- R4: With decimalEn high, subtract high and valid packed-decimal operands, result is the packed-decimal form of (A − B − (1 − carryIn)) mod 100, and carryOut is 1 exactly when that difference is not negative.
- R5: N is bit 7 and Z is the all-zero test of the intermediate sum. The intermediate sum is made of the nibble sums opA + opB' + carry, where opB' is opB (or ~opB when subtracting). The carry into the high nibble is the chosen carry: in decimal add mode it is 1 when the low nibble sum exceeds 9. Example: decimal add of 0x44 and 0x56 with carryIn 0 gives intermediate 0xAA, so result 0x00, carryOut 1, N 1, V 1, Z 0.
- R6: V is 1 exactly when bit 7 of opA equals bit 7 of opB' and bit 7 of the intermediate sum differs from them.
- R7: outValid follows inValid exactly two clock edges later. result, carryOut and the flags change only on cycles where outValid is high, and hold their values otherwise.
- R8: A synchronous reset (rst high at a clock edge) clears every pipeline register, so outValid, result, carryOut, N, V and Z all read 0 and no operation in flight ever emerges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands are presented this cycle |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Carry in (1 = no borrow when subtracting) |
| subtract | input | 1 | 1 selects A − B, 0 selects A + B |
| decimalEn | input | 1 | 1 selects packed-decimal arithmetic |
| outValid | output | 1 | Result of an operation issued two cycles earlier |
| result | output | 8 | Corrected result |
| carryOut | output | 1 | Carry out of the top nibble |
| flagN | output | 1 | Sign of the intermediate sum |
| flagV | output | 1 | Signed overflow of the intermediate sum |
| flagZ | output | 1 | Intermediate sum is zero |

## Verification
The digit-range assertion assumes that every operand presented in decimal mode is valid packed decimal, with no nibble above 9. Every decimal-mode stimulus is therefore built from numbers 0..99 converted to two digits. Only binary-mode stimulus sweeps all byte values. The hold and latency assertions assume that reset is applied before the first valid operation. The bench follows this by raising inValid only after reset is released, and it again holds inValid low while it pulses reset in the middle of the stream.

// File: rtl/bcdPkg.sv
package bcdPkg;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic ldStage1;
    logic ldStage2;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcdNibble.sv
module bcdNibble (
  input  logic       decMode,
  input  logic       subMode,
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cIn,
  output logic [3:0] sum,
  output logic       carrySel
);
  logic [4:0] full;
  logic       binCarry;
  logic       decCarry;

  always_comb begin
    full     = {1'b0, a} + {1'b0, b} + {4'b0000, cIn};
    binCarry = full[4];
    // decimal subtract of valid digits borrows exactly when binary does
    decCarry = subMode ? full[4] : (full > 5'd9);
    carrySel = decMode ? decCarry : binCarry;
    sum      = full[3:0];
  end
endmodule

// File: rtl/bcdDigitFix.sv
module bcdDigitFix (
  input  logic       decMode,
  input  logic       subMode,
  input  logic       carryBit,
  input  logic [3:0] rawDigit,
  output logic [3:0] fixedDigit
);
  logic [3:0] offset;

  always_comb begin
    offset = 4'd0;
    if (decMode) begin
      if (subMode) offset = carryBit ? 4'd0 : 4'd10;
      else         offset = carryBit ? 4'd6 : 4'd0;
    end
    fixedDigit = rawDigit + offset;
  end
endmodule

// File: rtl/bcdControl.sv
module bcdControl
  import bcdPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  logic vld1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1     <= 1'b0;
      outValid <= 1'b0;
    end else begin
      vld1     <= inValid;
      outValid <= vld1;
    end
  end

  always_comb begin
    strobes.ldStage1 = inValid;
    strobes.ldStage2 = vld1;
  end

  // R7: a valid operation emerges two edges later
  a_r7_latency_on: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);
  // R7: no output strobe without an operation two edges earlier
  a_r7_latency_off: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);
endmodule

// File: rtl/bcdDatapath.sv
module bcdDatapath
  import bcdPkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobes_t              ctrl,
  input  logic [DIGITS*NIB_W-1:0]   opA,
  input  logic [DIGITS*NIB_W-1:0]   opB,
  input  logic                      carryIn,
  input  logic                      subtract,
  input  logic                      decimalEn,
  output logic [DIGITS*NIB_W-1:0]   result,
  output logic                      carryOut,
  output logic                      flagN,
  output logic                      flagV,
  output logic                      flagZ
);
  localparam int W   = DIGITS * NIB_W;
  localparam int MSB = W - 1;

  logic [W-1:0]      effB;
  logic [W-1:0]      rawSum;
  logic [DIGITS:0]   chain;
  logic              ovfNow;

  logic [W-1:0]      sum1;
  logic [DIGITS-1:0] carry1;
  logic              dec1;
  logic              sub1;
  logic              ovf1;

  logic [W-1:0]      fixedSum;

  always_comb begin
    effB     = subtract ? ~opB : opB;
    chain[0] = carryIn;
    ovfNow   = (opA[MSB] == effB[MSB]) && (rawSum[MSB] != opA[MSB]);
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_nib
    bcdNibble u_nib (
      .decMode (decimalEn),
      .subMode (subtract),
      .a       (opA[NIB_W*i +: NIB_W]),
      .b       (effB[NIB_W*i +: NIB_W]),
      .cIn     (chain[i]),
      .sum     (rawSum[NIB_W*i +: NIB_W]),
      .carrySel(chain[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum1   <= '0;
      carry1 <= '0;
      dec1   <= 1'b0;
      sub1   <= 1'b0;
      ovf1   <= 1'b0;
    end else if (ctrl.ldStage1) begin
      sum1   <= rawSum;
      carry1 <= chain[DIGITS:1];
      dec1   <= decimalEn;
      sub1   <= subtract;
      ovf1   <= ovfNow;
    end
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_fix
    bcdDigitFix u_fix (
      .decMode   (dec1),
      .subMode   (sub1),
      .carryBit  (carry1[i]),
      .rawDigit  (sum1[NIB_W*i +: NIB_W]),
      .fixedDigit(fixedSum[NIB_W*i +: NIB_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      carryOut <= 1'b0;
      flagN    <= 1'b0;
      flagV    <= 1'b0;
      flagZ    <= 1'b0;
    end else if (ctrl.ldStage2) begin
      result   <= fixedSum;
      carryOut <= carry1[DIGITS-1];
      flagN    <= sum1[MSB];
      flagV    <= ovf1;
      flagZ    <= (sum1 == '0);
    end
  end

  // R7: outputs hold while no result is being written
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.ldStage2 |=> ($stable(result) && $stable(carryOut) && $stable(flagZ)));

  // R1: binary mode passes the captured sum through uncorrected
  a_r1_binary_pass: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ldStage2 && !dec1) |=> (result == $past(sum1)));

  for (genvar i = 0; i < DIGITS; i++) begin : g_chk
    // R3: corrected decimal digits stay within 0..9 (operands assumed valid)
    a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
      (ctrl.ldStage2 && dec1) |=> (result[NIB_W*i +: NIB_W] <= 4'd9));
  end
endmodule

// File: rtl/bcdAluPipe.sv
module bcdAluPipe
  import bcdPkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * NIB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  logic         subtract,
  input  logic         decimalEn,
  output logic         outValid,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic         flagN,
  output logic         flagV,
  output logic         flagZ
);
  ctrlStrobes_t strobes;

  bcdControl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  bcdDatapath #(.DIGITS(DIGITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (strobes),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .subtract (subtract),
    .decimalEn(decimalEn),
    .result   (result),
    .carryOut (carryOut),
    .flagN    (flagN),
    .flagV    (flagV),
    .flagZ    (flagZ)
  );
endmodule

// File: tb/bcdAluPipe_tb.sv
`timescale 1ns/1ps
module bcdAluPipe_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       inValid;
  logic [7:0] opA, opB;
  logic       carryIn, subtract, decimalEn;
  logic       outValid;
  logic [7:0] result;
  logic       carryOut, flagN, flagV, flagZ;

  always #2.5 clk = ~clk;

  bcdAluPipe u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .carryIn(carryIn), .subtract(subtract), .decimalEn(decimalEn),
    .outValid(outValid), .result(result), .carryOut(carryOut),
    .flagN(flagN), .flagV(flagV), .flagZ(flagZ)
  );

  typedef struct {
    bit         v;
    logic [7:0] res;
    bit         c, n, vf, z;
    string      req;
  } exp_t;

  int   nChecks = 0;
  int   nFail   = 0;
  bit   finished = 0;
  exp_t e0, e1, lastE;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] toBcd(input int x);
    return {4'(x / 10), 4'(x % 10)};
  endfunction

  function automatic exp_t model(input bit v, input logic [7:0] a, input logic [7:0] b,
                                 input bit cin, input bit sub, input bit dec);
    exp_t e;
    logic [7:0] bE;
    int lo, hi, lc, full, da, db, d;
    logic [7:0] inter;
    e.v = v;
    bE = sub ? ~b : b;
    // intermediate: nibble sums with chosen carry into the high nibble
    lo = int'(a[3:0]) + int'(bE[3:0]) + int'(cin);
    if (dec && !sub) lc = (lo > 9) ? 1 : 0;
    else             lc = (lo > 15) ? 1 : 0;
    hi = int'(a[7:4]) + int'(bE[7:4]) + lc;
    inter = {4'(hi), 4'(lo)};
    e.n  = inter[7];
    e.z  = (inter == 8'h00);
    e.vf = (a[7] == bE[7]) && (inter[7] != a[7]);
    if (!dec) begin
      full  = int'(a) + int'(bE) + int'(cin);
      e.res = 8'(full);
      e.c   = (full > 255);
      e.req = sub ? "R2" : "R1";
    end else begin
      da = int'(a[7:4]) * 10 + int'(a[3:0]);
      db = int'(b[7:4]) * 10 + int'(b[3:0]);
      if (sub) begin
        d = da - db - (1 - int'(cin));
        e.c   = (d >= 0);
        e.res = toBcd((d + 100) % 100);
        e.req = "R4";
      end else begin
        d = da + db + int'(cin);
        e.c   = (d >= 100);
        e.res = toBcd(d % 100);
        e.req = "R3";
      end
    end
    return e;
  endfunction

  task automatic cyc(input bit v, input logic [7:0] a, input logic [7:0] b,
                     input bit cin, input bit sub, input bit dec);
    @(negedge clk);
    if (e1.v) begin
      chk(outValid == 1'b1, "R7", "outValid", outValid, 1);
      chk(result == e1.res && carryOut == e1.c, e1.req, "result/carry",
          {carryOut, result}, {e1.c, e1.res});
      chk(flagN == e1.n && flagZ == e1.z, "R5", "N/Z", {flagN, flagZ}, {e1.n, e1.z});
      chk(flagV == e1.vf, "R6", "V", flagV, e1.vf);
      lastE = e1;
    end else begin
      chk(outValid == 1'b0 && result == lastE.res && carryOut == lastE.c &&
          flagN == lastE.n && flagV == lastE.vf && flagZ == lastE.z,
          "R7", "hold", {outValid, carryOut, flagN, flagV, flagZ, result},
          {1'b0, lastE.c, lastE.n, lastE.vf, lastE.z, lastE.res});
    end
    e1 = e0;
    inValid   = v;
    opA       = a;
    opB       = b;
    carryIn   = cin;
    subtract  = sub;
    decimalEn = dec;
    e0 = model(v, a, b, cin, sub, dec);
  endtask

  task automatic clearModel();
    e0 = '{v: 0, res: 8'h00, c: 0, n: 0, vf: 0, z: 0, req: "R7"};
    e1 = e0;
    lastE = e0;
  endtask

  task automatic checkReset();
    chk(outValid == 0 && result == 8'h00 && carryOut == 0 && flagN == 0 &&
        flagV == 0 && flagZ == 0, "R8", "reset state",
        {outValid, carryOut, flagN, flagV, flagZ, result}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R7 watchdog: actual %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    clearModel();
    rst = 1'b1; inValid = 1'b0; opA = 8'h00; opB = 8'h00;
    carryIn = 1'b0; subtract = 1'b0; decimalEn = 1'b0;
    repeat (3) @(negedge clk);
    checkReset();                                   // R8 initial state
    rst = 1'b0;

    // R5 worked example: decimal 0x44 + 0x56
    cyc(1, 8'h44, 8'h56, 0, 0, 1);
    cyc(0, 8'hFF, 8'hFF, 1, 1, 0);
    cyc(0, 8'h12, 8'h34, 1, 0, 1);
    @(negedge clk);
    chk(result == 8'h00 && carryOut == 1 && flagN == 1 && flagV == 1 && flagZ == 0,
        "R5", "worked example", {carryOut, flagN, flagV, flagZ, result}, 12'he00);

    // R1 R2: binary sweep, all A against a spread of B, both carries and modes
    for (int a = 0; a < 256; a++) begin
      for (int bi = 0; bi < 16; bi++) begin
        for (int m = 0; m < 4; m++) begin
          cyc(1, 8'(a), 8'(bi * 17), m[0], m[1], 0);
        end
        if (((a + bi) % 7) == 0) cyc(0, 8'(a), 8'h5A, 1, 1, 1);  // R7 gap
      end
    end

    // R3 R4: every pair of valid two-digit decimal operands
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        for (int m = 0; m < 4; m++) begin
          cyc(1, toBcd(x), toBcd(y), m[0], m[1], 1);
        end
        if (((x * 3 + y) % 11) == 0) cyc(0, 8'h99, 8'h01, 0, 0, 1);  // R7 gap
      end
    end

    // R8: reset with operations in flight
    cyc(1, 8'h99, 8'h01, 0, 0, 1);
    cyc(1, 8'hF0, 8'h0F, 1, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    checkReset();
    rst = 1'b0;
    clearModel();
    cyc(0, 8'h00, 8'h00, 0, 0, 0);
    cyc(0, 8'h00, 8'h00, 0, 0, 0);
    cyc(0, 8'h00, 8'h00, 0, 0, 0);                  // R8 nothing emerges

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule